// File: doc/BRIEF.md
# Rate-Selectable Time-Slot Interchange Switch

This block moves 64 kb/s channels between serial time-division streams. Each of the input streams carries one byte per channel per 8 kHz frame, sent most significant bit first. Every incoming byte is written into a data store addressed by bank, stream and channel. On the output side, a routing table names the source stream and source channel for every output stream and channel. The byte it names is then sent in the following frame.

A two-bit rate code sets the channels per frame: 32, 64 or 128 at the default parameters, for 2.048, 4.096 or 8.192 Mb/s links. That gives a matrix of 512, 1,024 or 2,048 channels each way. Each bit lasts two clock cycles, so the required clock is 4.096, 8.192 or 16.384 MHz. A small register port writes the rate code and the routing table, and reads them back. The block runs its own frame counter and marks cycle 0 of each frame on `frame_o`, so the neighbouring framing logic can align the serial streams to it.

Top module: `tsi_switch`

## Requirements
- R1: A frame lasts 16·N clock cycles, where N is BASE_CH, 2·BASE_CH or 4·BASE_CH channels for rate code 00, 01 or 10 (32/64/128 by default). `frame_o` is high only in the first cycle of each frame, and it is high in the first cycle after reset.
- R2: Rate code 11 gives the same frame length and routing as code 00.
- R3: A new rate code takes effect at the next frame boundary. The frame in progress ends at its old length.
- R4: Each bit occupies two cycles. Bit k of channel c (k=0 is the MSB) occupies frame cycles 16c+2k and 16c+2k+1. An input bit is taken at the second of those cycles, and an output bit is held steady over both. `soe` is constant within a channel.
- R5: Output stream o, channel c, in frame F carries the byte that its routing entry selects, as received in frame F-1. This also holds when the source is the last channel of frame F-1 and the output is channel 0 of frame F.
- R6: A register write with address MSB 0 loads a routing entry. The output channel is in the low CHW address bits and the output stream in the next SW bits. The data holds the source channel in the low CHW bits, the source stream in the next SW bits, and the enable in the MSB. Reading the same address returns the entry.
- R7: When the routing entry for an output channel is disabled, `soe` is low and `sout` is 1 for that whole channel.
- R8: A write with address MSB 1 loads the rate code from data bits [1:0], and the other address bits are ignored. A read with address MSB 1 returns the code in bits [1:0] and zeros above.
- R9: In the source channel field, bits at or above the current frame's channel count are ignored, so the channel used is the field value modulo N.
- R10: After reset, all routing enables are clear, `soe` is all zero, `sout` is all ones and the rate code reads 00.
- R11: Any number of outputs may name the same source, and each of them carries that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, two cycles per bit |
| rst | input | 1 | Synchronous reset, active high |
| sin | input | STREAMS | Serial input streams |
| sout | output | STREAMS | Serial output streams, 1 when disabled |
| soe | output | STREAMS | Output drive enable per stream for the current channel |
| frame_o | output | 1 | High in the first cycle of each frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address: MSB selects rate code or routing entry |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data, combinational from `reg_addr` |

## Verification
On every cycle, the bound checker watches frame lengths against the legal range. It also checks that outputs hold each bit for its two cycles, that enables change only at channel boundaries, that a disabled output idles high, and the state in the first cycle after reset. The exact byte routing, the one-frame delay through the double buffer, the last-channel wrap, the channel masking and the timing of rate changes are shown only by the bench scenarios. The bench replays each routing map against bytes it generates per frame, stream and channel. It also measures every frame length against the rate latched at that frame's start.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [1:0] {
        RATE_1X  = 2'b00,
        RATE_2X  = 2'b01,
        RATE_4X  = 2'b10,
        RATE_RSV = 2'b11
    } rate_e;

    // Left shift applied to the base channel count; the reserved code acts as 1x.
    function automatic logic [1:0] rate_shift(input rate_e r);
        unique case (r)
            RATE_2X: return 2'd1;
            RATE_4X: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int BASE_CH = 32,
    parameter int CYW     = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     rate_req,
    output logic [CYW-1:0] cyc_o,
    output logic [CYW-1:0] cyc_nx_o,
    output logic [1:0]     shift_nx_o,
    output logic           bank_o,
    output logic           bank_nx_o,
    output logic           wrap_o,
    output logic           frame_o
);

    typedef struct packed {
        logic [CYW-1:0] cyc;
        logic [1:0]     shift;
        logic           bank;
    } tm_t;

    localparam logic [CYW:0] BASE_CYC = (CYW+1)'(BASE_CH * 16);

    tm_t tm_d, tm_q;
    logic [CYW:0] len, len_m1;
    logic         last;

    always_comb begin
        tm_d   = tm_q;
        len    = BASE_CYC << tm_q.shift;
        len_m1 = len - (CYW+1)'(1);
        last   = ({1'b0, tm_q.cyc} == len_m1);
        if (last) begin
            tm_d.cyc   = '0;
            tm_d.shift = rate_shift(rate_e'(rate_req));
            tm_d.bank  = ~tm_q.bank;
        end else begin
            tm_d.cyc = tm_q.cyc + CYW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign cyc_o      = tm_q.cyc;
    assign cyc_nx_o   = tm_d.cyc;
    assign shift_nx_o = tm_d.shift;
    assign bank_o     = tm_q.bank;
    assign bank_nx_o  = tm_d.bank;
    assign wrap_o     = last;
    assign frame_o    = (tm_q.cyc == '0);

endmodule

// File: rtl/tsi_regs.sv
module tsi_regs #(
    parameter int STREAMS = 16,
    parameter int SW      = 4,
    parameter int CHW     = 7,
    parameter int W       = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [W-1:0]              addr,
    input  logic [W-1:0]              wdata,
    output logic [W-1:0]              rdata,
    output logic [1:0]                rate_o,
    input  logic [CHW-1:0]            rd_ch,
    output logic [STREAMS-1:0][W-1:0] ent_o
);

    localparam int DEPTH = STREAMS << CHW;
    localparam int IW    = SW + CHW;

    typedef struct packed {
        logic [1:0]       rate;
        logic [DEPTH-1:0] oe;
    } rg_t;

    rg_t rg_d, rg_q;
    logic [IW-1:0] route_q [DEPTH];
    logic [IW-1:0] idx;

    assign idx = addr[W-2:0];

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            if (addr[W-1]) begin
                rg_d.rate = wdata[1:0];
            end else begin
                rg_d.oe[idx] = wdata[W-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    // Source fields carry no reset: the enable bits alone gate their use.
    always_ff @(posedge clk) begin
        if (wr_en && !addr[W-1]) begin
            route_q[idx] <= wdata[W-2:0];
        end
    end

    assign rdata  = addr[W-1] ? {(W-2)'(0), rg_q.rate} : {rg_q.oe[idx], route_q[idx]};
    assign rate_o = rg_q.rate;

    for (genvar o = 0; o < STREAMS; o++) begin : g_rd
        logic [IW-1:0] ri;
        assign ri       = {SW'(o), rd_ch};
        assign ent_o[o] = {rg_q.oe[ri], route_q[ri]};
    end

endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
    parameter int STREAMS = 16,
    parameter int SW      = 4,
    parameter int CHW     = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [STREAMS-1:0]            sin,
    input  logic                          cap_en,
    input  logic                          wr_en,
    input  logic                          wr_bank,
    input  logic [CHW-1:0]                wr_ch,
    output logic [STREAMS-1:0][7:0]       cap_byte_o,
    input  logic [STREAMS-1:0][SW+CHW:0]  raddr,
    output logic [STREAMS-1:0][7:0]       rdata
);

    localparam int DEPTH = 2 * (STREAMS << CHW);

    typedef struct packed {
        logic [STREAMS-1:0][6:0] sr;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [7:0] mem [DEPTH];

    always_comb begin
        rx_d = rx_q;
        if (cap_en) begin
            for (int s = 0; s < STREAMS; s++) begin
                rx_d.sr[s] = {rx_q.sr[s][5:0], sin[s]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    for (genvar s = 0; s < STREAMS; s++) begin : g_port
        assign cap_byte_o[s] = {rx_q.sr[s], sin[s]};
        assign rdata[s]      = mem[raddr[s]];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int s = 0; s < STREAMS; s++) begin
                mem[{wr_bank, SW'(s), wr_ch}] <= cap_byte_o[s];
            end
        end
    end

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx #(
    parameter int STREAMS = 16,
    parameter int SW      = 4,
    parameter int CHW     = 7,
    parameter int BASE_CH = 32,
    parameter int W       = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [1:0]                    shift_nx,
    input  logic                          rd_bank,
    input  logic                          fwd,
    input  logic [CHW-1:0]                ch_cur,
    input  logic [2:0]                    bit_cur,
    input  logic [STREAMS-1:0][W-1:0]     ent,
    input  logic [STREAMS-1:0][7:0]       cap_byte,
    input  logic [STREAMS-1:0][7:0]       dm_rdata,
    output logic [STREAMS-1:0][SW+CHW:0]  dm_raddr,
    output logic [STREAMS-1:0]            sout,
    output logic [STREAMS-1:0]            soe
);

    typedef struct packed {
        logic [STREAMS-1:0][7:0] data;
        logic [STREAMS-1:0]      en;
    } tx_t;

    tx_t tx_d, tx_q;
    logic [CHW:0]   span, span_m1;
    logic [CHW-1:0] mask;
    logic [STREAMS-1:0][SW-1:0]  src_s;
    logic [STREAMS-1:0][CHW-1:0] src_c;

    assign span    = (CHW+1)'(BASE_CH) << shift_nx;
    assign span_m1 = span - (CHW+1)'(1);
    assign mask    = span_m1[CHW-1:0];

    always_comb begin
        tx_d = tx_q;
        for (int o = 0; o < STREAMS; o++) begin
            src_s[o]    = ent[o][CHW+SW-1:CHW];
            src_c[o]    = ent[o][CHW-1:0] & mask;
            dm_raddr[o] = {rd_bank, src_s[o], src_c[o]};
            if (load) begin
                // At a frame wrap the last channel is being written this very edge.
                tx_d.data[o] = (fwd && src_c[o] == ch_cur) ? cap_byte[src_s[o]] : dm_rdata[o];
                tx_d.en[o]   = ent[o][W-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    for (genvar o = 0; o < STREAMS; o++) begin : g_out
        assign sout[o] = tx_q.en[o] ? tx_q.data[o][3'd7 - bit_cur] : 1'b1;
    end
    assign soe = tx_q.en;

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int STREAMS = 16,
    parameter int BASE_CH = 32,
    parameter int AW      = 1 + $clog2(STREAMS) + $clog2(BASE_CH * 4)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STREAMS-1:0] sin,
    output logic [STREAMS-1:0] sout,
    output logic [STREAMS-1:0] soe,
    output logic               frame_o,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [AW-1:0]      reg_wdata,
    output logic [AW-1:0]      reg_rdata
);

    localparam int MAX_CH = BASE_CH * 4;
    localparam int SW     = $clog2(STREAMS);
    localparam int CHW    = $clog2(MAX_CH);
    localparam int CYW    = CHW + 4;

    logic [CYW-1:0] cyc, cyc_nx;
    logic [1:0]     shift_nx, rate;
    logic           bank, bank_nx, wrap;
    logic           cap_last, load;
    logic [STREAMS-1:0][AW-1:0]     ent;
    logic [STREAMS-1:0][7:0]        cap_byte, dm_rdata;
    logic [STREAMS-1:0][SW+CHW:0]   dm_raddr;

    assign cap_last = (cyc[3:0] == 4'hF);
    assign load     = (cyc_nx[3:0] == 4'h0);

    tsi_timing #(.BASE_CH(BASE_CH), .CYW(CYW)) u_timing (
        .clk(clk), .rst(rst), .rate_req(rate),
        .cyc_o(cyc), .cyc_nx_o(cyc_nx), .shift_nx_o(shift_nx),
        .bank_o(bank), .bank_nx_o(bank_nx), .wrap_o(wrap), .frame_o(frame_o)
    );

    tsi_regs #(.STREAMS(STREAMS), .SW(SW), .CHW(CHW), .W(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .rate_o(rate), .rd_ch(cyc_nx[CYW-1:4]), .ent_o(ent)
    );

    tsi_dmem #(.STREAMS(STREAMS), .SW(SW), .CHW(CHW)) u_dmem (
        .clk(clk), .rst(rst), .sin(sin), .cap_en(cyc[0]), .wr_en(cap_last),
        .wr_bank(bank), .wr_ch(cyc[CYW-1:4]), .cap_byte_o(cap_byte),
        .raddr(dm_raddr), .rdata(dm_rdata)
    );

    tsi_tx #(.STREAMS(STREAMS), .SW(SW), .CHW(CHW), .BASE_CH(BASE_CH), .W(AW)) u_tx (
        .clk(clk), .rst(rst), .load(load), .shift_nx(shift_nx), .rd_bank(~bank_nx),
        .fwd(wrap), .ch_cur(cyc[CYW-1:4]), .bit_cur(cyc[3:1]), .ent(ent),
        .cap_byte(cap_byte), .dm_rdata(dm_rdata), .dm_raddr(dm_raddr),
        .sout(sout), .soe(soe)
    );

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int STREAMS = 16,
    parameter int BASE_CH = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_o,
    input logic [STREAMS-1:0] sout,
    input logic [STREAMS-1:0] soe
);

    localparam int MAX_CYC = 16 * BASE_CH * 4;
    localparam int PW      = $clog2(MAX_CYC) + 2;

    logic [PW-1:0] pos_q, cur;
    logic          started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            started_q <= 1'b0;
        end else begin
            pos_q     <= frame_o ? PW'(1) : pos_q + PW'(1);
            started_q <= started_q | frame_o;
        end
    end

    assign cur = frame_o ? '0 : pos_q;

    // R1: frame length stays within the legal range of rates
    a_r1_frame_len: assert property (@(posedge clk) disable iff (rst)
        (frame_o && started_q) |-> (pos_q >= PW'(16 * BASE_CH) && pos_q <= PW'(MAX_CYC)));

    a_r1_no_overrun: assert property (@(posedge clk) disable iff (rst)
        pos_q <= PW'(MAX_CYC));

    a_r4_bit_hold: assert property (@(posedge clk) disable iff (rst)
        cur[0] |-> $stable(sout));

    a_r4_enable_per_channel: assert property (@(posedge clk) disable iff (rst)
        (cur[3:0] != 4'h0) |-> $stable(soe));

    a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
        ((~soe) & (~sout)) == '0);

    a_r10_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (frame_o && soe == '0 && sout == '1));

endmodule

bind tsi_switch tsi_switch_chk #(.STREAMS(STREAMS), .BASE_CH(BASE_CH)) u_chk (
    .clk(clk), .rst(rst), .frame_o(frame_o), .sout(sout), .soe(soe)
);

// File: tb/tsi_switch_test.sv
module tsi_switch_test;

    localparam int S  = 4;
    localparam int B  = 4;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [S-1:0]  sin = '0;
    logic [S-1:0]  sout, soe;
    logic          frame_o;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;

    int total = 0;
    int failed = 0;
    int map_s [S][16];
    int map_c [S][16];
    bit map_e [S][16];
    int pend_rate = 0;
    int cur_nch = 4;
    bit chk_en = 1'b0;
    string tag = "R5";

    tsi_switch #(.STREAMS(S), .BASE_CH(B)) uut (
        .clk(clk), .rst(rst), .sin(sin), .sout(sout), .soe(soe), .frame_o(frame_o),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;

    function automatic int nch_of(int r);
        return (r == 1) ? 8 : (r == 2) ? 16 : 4;
    endfunction

    function automatic logic [7:0] pat(int f, int s, int c);
        return 8'((s * 37 + c * 5 + f * 11 + 3) & 255);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    task automatic reg_write(logic [AW-1:0] a, logic [AW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_expect(logic [AW-1:0] a, logic [AW-1:0] exp, string req);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(reg_rdata === exp, req, int'(reg_rdata), int'(exp));
    endtask

    // R6: address {0, stream[1:0], channel[3:0]}; data {enable, stream[1:0], channel[3:0]}
    task automatic set_route(int o, int c, int s, int sc, bit e);
        reg_write({1'b0, 2'(o), 4'(c)}, {e, 2'(s), 4'(sc)});
        map_s[o][c] = s; map_c[o][c] = sc; map_e[o][c] = e;
    endtask

    task automatic wait_frames(int n);
        repeat (n) begin
            do @(negedge clk); while (frame_o !== 1'b1);
        end
    endtask

    // R3: rate written mid-frame, never near a boundary
    task automatic set_rate(logic [AW-1:0] a, int r);
        wait_frames(1);
        repeat (5) @(negedge clk);
        reg_write(a, AW'(r));
        pend_rate = r & 3;
    endtask

    task automatic run_checked(string t);
        tag = t;
        wait_frames(3);
        chk_en = 1'b1;
        wait_frames(3);
        chk_en = 1'b0;
    endtask

    // Stimulus and monitor: one pass per cycle, on the falling edge
    initial begin
        int pos = 0;
        int fidx = 0;
        bit started = 1'b0;
        logic [7:0] ob [S];
        logic oe_seen [S];
        forever begin
            @(negedge clk);
            if (rst) begin
                pos = 0;
                started = 1'b0;
                continue;
            end
            if (frame_o) begin
                // R1 R2 R3: finished frame length set by the rate latched at its start
                if (started) check(pos + 1 == 16 * cur_nch, "R1 R2 R3 frame length", pos + 1, 16 * cur_nch);
                fidx++;
                cur_nch = nch_of(pend_rate);
                pos = 0;
                started = 1'b1;
            end else begin
                pos++;
            end
            for (int s = 0; s < S; s++) begin
                logic [7:0] pv;
                pv = pat(fidx, s, pos >> 4);
                sin[s] = pv[7 - ((pos >> 1) & 7)];
            end
            if (pos % 2 == 1) begin
                for (int o = 0; o < S; o++) begin
                    ob[o][7 - ((pos >> 1) & 7)] = sout[o];
                    oe_seen[o] = soe[o];
                end
            end
            if (pos % 16 == 15 && chk_en && fidx >= 3) begin
                for (int o = 0; o < S; o++) begin
                    int c;
                    logic [7:0] exp;
                    c = pos >> 4;
                    exp = map_e[o][c] ? pat(fidx - 1, map_s[o][c], map_c[o][c] & (cur_nch - 1)) : 8'hFF;
                    check(ob[o] === exp, tag, int'(ob[o]), int'(exp));
                    check(oe_seen[o] === map_e[o][c], tag, int'(oe_seen[o]), int'(map_e[o][c]));
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state at the ports and through the register port
        check(soe === '0, "R10 soe", int'(soe), 0);
        check(sout === '1, "R10 sout", int'(sout), 15);
        reg_expect(7'h40, 7'h00, "R8 R10 rate reset");
        reg_expect(7'h25, 7'h00, "R10 routing enable reset");
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(frame_o === 1'b1, "R1 first frame cycle", int'(frame_o), 1);

        // R4 R5: reversed channels, rotated streams; last channel lands in channel 0
        for (int o = 0; o < S; o++)
            for (int c = 0; c < 16; c++)
                set_route(o, c, (o + 1) % S, 15 - c, 1'b1);
        reg_expect({1'b0, 2'd2, 4'd3}, {1'b1, 2'd3, 4'd12}, "R6 readback");
        reg_expect({1'b0, 2'd0, 4'd15}, {1'b1, 2'd1, 4'd0}, "R6 readback");
        run_checked("R4 R5 R6");

        // R11 broadcast of one source; R7 output 3 disabled
        for (int o = 0; o < S; o++)
            for (int c = 0; c < 4; c++)
                set_route(o, c, 2, 1, o != 3);
        reg_expect({1'b0, 2'd3, 4'd2}, {1'b0, 2'd2, 4'd1}, "R6 R7 readback");
        run_checked("R7 R11");

        // R9: channel field bits above the channel count are ignored
        for (int o = 0; o < S; o++)
            for (int c = 0; c < 4; c++)
                set_route(o, c, o, c | 12, 1'b1);
        run_checked("R9");

        // R1 R3: 2x rate, written mid-frame
        for (int o = 0; o < S; o++)
            for (int c = 0; c < 16; c++)
                set_route(o, c, (o + 3) % S, 15 - c, (c % 5) != 2);
        set_rate(7'h40, 1);
        run_checked("R1 R3 R5 at 2x");

        // R1: 4x rate
        set_rate(7'h40, 2);
        run_checked("R1 R5 at 4x");

        // R2: reserved code acts as 1x; R8: low address bits ignored for the rate write
        set_rate(7'h7F, 3);
        reg_expect(7'h40, 7'h03, "R8 rate readback");
        run_checked("R2 R5 reserved rate");

        finish_run();
    end

endmodule